// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Interrupt

This block holds bytes arriving from a serial receive engine until firmware collects them. It is a 16-entry first-in, first-out byte store. The serial engine offers a byte together with a one-cycle valid strobe. Each read of the data register pops the oldest byte, so firmware can keep reading until the queue reports empty.

A programmable fill threshold is held in zero-based form: writing N-1 asks for an interrupt once N bytes are waiting. The occupancy output is zero-based as well and reads the number of held bytes minus one. A status byte carries an empty bit and a full bit. Firmware normally sets the threshold to the number of bytes it still expects, capped at 16, and changes it between bursts.

The interrupt status bit is set whenever the fill condition holds and stays set until firmware clears it. A byte that arrives while the queue is full is discarded and sets a sticky overflow flag.

Top module: `rx_byte_queue`

## Requirements
- R1: The queue holds up to 16 bytes and returns them oldest first. A pop request on a non-empty queue places the oldest byte on `pop_byte` at the clock edge where the pop is taken.
- R2: `occ_m1` reads the number of held bytes minus one, and reads 0 when the queue is empty.
- R3: `status_byte` bit 6 is 1 exactly while the queue is empty, and bit 5 is 1 exactly while it holds 16 bytes. All other bits read 0, so an empty queue reads 0x40 and a full one reads 0x20.
- R4: A byte offered while the queue is full, with no pop in the same cycle, is discarded and leaves the contents unchanged. It sets `ovf_flag`, which stays set until a cycle with `ovf_clr` high.
- R5: A pop request on an empty queue leaves `pop_byte` at its previous value and keeps the queue empty. The pointers do not wrap, so later bytes are still returned in order.
- R6: `thr_q` holds the zero-based threshold. It resets to 15 and loads `thr_wdata` at the edge where `thr_we` is high.
- R7: `irq_stat` is set at the edge after one in which the held count is at least `thr_q`+1. While that condition holds, `irq_clr` does not clear it. It is cleared by `irq_clr` only in a cycle where the condition is false.
- R8: A push and a pop in the same cycle both take effect, including when the queue is full: the count stays the same and no overflow is flagged.
- R9: After synchronous reset the queue is empty, `occ_m1` is 0, `status_byte` is 0x40, `thr_q` is 15, and `irq_stat`, `ovf_flag` and `pop_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Byte strobe from the serial engine |
| push_byte | input | 8 | Received byte |
| pop_req | input | 1 | Data register read strobe; pops one byte |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | 4 | New zero-based threshold |
| irq_clr | input | 1 | Clear request for the interrupt status bit |
| ovf_clr | input | 1 | Clear request for the overflow flag |
| pop_byte | output | 8 | Byte returned by the last successful pop |
| occ_m1 | output | 4 | Held byte count minus one |
| status_byte | output | 8 | Bit 6 empty, bit 5 full |
| thr_q | output | 4 | Current zero-based threshold |
| irq_stat | output | 1 | Latched fill-level interrupt status |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench fills the queue to all 16 entries and offers one more byte. A design that let this byte through would overwrite the oldest entry and corrupt the order of the later drain. It then pushes and pops in the same cycle at full; a design that gave the drop rule priority would lose that byte or wrongly set overflow. It pops an empty queue, which exposes a pointer that underflows, because the bytes pushed afterwards would come back out of order. It also checks the threshold one below and exactly at the trigger count and tries to clear while the condition still holds, which catches an off-by-one in the zero-based compare and an interrupt that clears too early.

// File: rtl/rbq_pkg.sv
package rbq_pkg;

    localparam int STAT_EMPTY_BIT = 6;
    localparam int STAT_FULL_BIT  = 5;

    typedef struct packed {
        logic empty;
        logic full;
    } fill_t;

    function automatic logic [7:0] mk_status(input fill_t f);
        logic [7:0] s;
        s = '0;
        s[STAT_EMPTY_BIT] = f.empty;
        s[STAT_FULL_BIT]  = f.full;
        return s;
    endfunction

endpackage

// File: rtl/rbq_store.sv
module rbq_store #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count,
    output logic          drop
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          empty, full, do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop_req && !empty;
    assign do_push = push_valid && (!full || do_pop);
    assign drop    = push_valid && full && !do_pop;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            pop_data <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) begin
                rd_ptr   <= rd_ptr + 1'b1;
                pop_data <= mem[rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push_valid && !pop_req) |=> (count == $past(count))); // R4
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_req) |=> $stable(pop_data)); // R5
    AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (push_valid && pop_req && !empty) |=> $stable(count)); // R8
endmodule

// File: rtl/rbq_thresh.sv
module rbq_thresh #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic          thr_we,
    input  logic [AW-1:0] thr_wdata,
    input  logic          irq_clr,
    output logic [AW-1:0] thr,
    output logic          irq
);
    logic hit;

    assign hit = (count > {1'b0, thr});

    always_ff @(posedge clk) begin
        if (rst) begin
            thr <= AW'(DEPTH - 1);
            irq <= 1'b0;
        end else begin
            if (thr_we) thr <= thr_wdata;
            irq <= hit | (irq & ~irq_clr);
        end
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        (count > {1'b0, thr}) |=> irq); // R7
    AST_THR_LOAD: assert property (@(posedge clk) disable iff (rst)
        thr_we |=> (thr == $past(thr_wdata))); // R6
endmodule

// File: rtl/rbq_flags.sv
module rbq_flags
    import rbq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic          drop,
    input  logic          ovf_clr,
    output logic [AW-1:0] occ_m1,
    output logic [7:0]    status,
    output logic          ovf
);
    fill_t fill;
    logic [CW-1:0] cnt_dec;

    assign fill.empty = (count == '0);
    assign fill.full  = (count == CW'(DEPTH));
    assign cnt_dec    = count - 1'b1;
    assign occ_m1     = fill.empty ? '0 : cnt_dec[AW-1:0];
    assign status     = mk_status(fill);

    always_ff @(posedge clk) begin
        if (rst) ovf <= 1'b0;
        else     ovf <= drop | (ovf & ~ovf_clr);
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf); // R4
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(status[STAT_EMPTY_BIT] && status[STAT_FULL_BIT])); // R3
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_valid,
    input  logic [7:0]    push_byte,
    input  logic          pop_req,
    input  logic          thr_we,
    input  logic [AW-1:0] thr_wdata,
    input  logic          irq_clr,
    input  logic          ovf_clr,
    output logic [7:0]    pop_byte,
    output logic [AW-1:0] occ_m1,
    output logic [7:0]    status_byte,
    output logic [AW-1:0] thr_q,
    output logic          irq_stat,
    output logic          ovf_flag
);
    logic [CW-1:0] count;
    logic          drop;

    rbq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_data(push_byte),
        .pop_req(pop_req), .pop_data(pop_byte),
        .count(count), .drop(drop)
    );

    rbq_thresh #(.DEPTH(DEPTH)) u_thresh (
        .clk(clk), .rst(rst), .count(count),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .irq_clr(irq_clr),
        .thr(thr_q), .irq(irq_stat)
    );

    rbq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst(rst), .count(count), .drop(drop), .ovf_clr(ovf_clr),
        .occ_m1(occ_m1), .status(status_byte), .ovf(ovf_flag)
    );
endmodule

// File: tb/rx_byte_queue_tb.sv
module rx_byte_queue_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push_valid = 1'b0;
    logic [7:0] push_byte = '0;
    logic       pop_req = 1'b0;
    logic       thr_we = 1'b0;
    logic [3:0] thr_wdata = '0;
    logic       irq_clr = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] pop_byte;
    logic [3:0] occ_m1;
    logic [7:0] status_byte;
    logic [3:0] thr_q;
    logic       irq_stat;
    logic       ovf_flag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    rx_byte_queue dut_i (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_byte(push_byte),
        .pop_req(pop_req), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .irq_clr(irq_clr), .ovf_clr(ovf_clr), .pop_byte(pop_byte),
        .occ_m1(occ_m1), .status_byte(status_byte), .thr_q(thr_q),
        .irq_stat(irq_stat), .ovf_flag(ovf_flag)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // op: 0 push, 1 pop, 2 threshold write, 3 push and pop
    // fields: [23:22] op, [21:14] data, [13:10] occ, [9] empty, [8] full, [7:0] popped byte
    localparam logic [23:0] VEC [11] = '{
        {2'd2, 8'h02, 4'd0, 1'b1, 1'b0, 8'h00},
        {2'd0, 8'hA1, 4'd0, 1'b0, 1'b0, 8'h00},
        {2'd0, 8'hB2, 4'd1, 1'b0, 1'b0, 8'h00},
        {2'd0, 8'hC3, 4'd2, 1'b0, 1'b0, 8'h00},
        {2'd1, 8'h00, 4'd1, 1'b0, 1'b0, 8'hA1},
        {2'd3, 8'hD4, 4'd1, 1'b0, 1'b0, 8'hB2},
        {2'd1, 8'h00, 4'd0, 1'b0, 1'b0, 8'hC3},
        {2'd1, 8'h00, 4'd0, 1'b1, 1'b0, 8'hD4},
        {2'd1, 8'h00, 4'd0, 1'b1, 1'b0, 8'hD4},
        {2'd0, 8'h5E, 4'd0, 1'b0, 1'b0, 8'h00},
        {2'd1, 8'h00, 4'd0, 1'b1, 1'b0, 8'h5E}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, take one rising edge, return at the next falling edge
    task automatic step(input logic pv, input logic [7:0] pb, input logic pr,
                        input logic tw, input logic [3:0] td,
                        input logic ic, input logic oc);
        push_valid = pv; push_byte = pb; pop_req = pr;
        thr_we = tw; thr_wdata = td; irq_clr = ic; ovf_clr = oc;
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0; pop_req = 1'b0; thr_we = 1'b0;
        irq_clr = 1'b0; ovf_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9 status after reset", status_byte, 8'h40);
        chk("R9 occ after reset", occ_m1, 0);
        chk("R9 thr after reset", thr_q, 15);
        chk("R9 irq after reset", irq_stat, 0);
        chk("R9 ovf after reset", ovf_flag, 0);
        rst = 1'b0;

        // table walk: R1 R2 R3 R5 R6 R8
        for (int i = 0; i < 11; i++) begin
            logic [1:0] op;
            op = VEC[i][23:22];
            step(op == 2'd0 || op == 2'd3, VEC[i][21:14], op == 2'd1 || op == 2'd3,
                 op == 2'd2, VEC[i][17:14], 1'b0, 1'b0);
            chk($sformatf("R2 occ vec %0d", i), occ_m1, VEC[i][13:10]);
            chk($sformatf("R3 status vec %0d", i), status_byte,
                {1'b0, VEC[i][9], VEC[i][8], 5'b0});
            if (op == 2'd1 || op == 2'd3)
                chk($sformatf("R1 R5 popped byte vec %0d", i), pop_byte, VEC[i][7:0]);
            if (op == 2'd2)
                chk("R6 threshold load", thr_q, 2);
        end

        // R7: queue empty, threshold 2 (three bytes); earlier latch cleared now
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R7 clear when condition false", irq_stat, 0);
        step(1, 8'h01, 0, 0, 0, 0, 0);
        step(1, 8'h02, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R7 no irq one below trigger", irq_stat, 0);
        step(1, 8'h03, 0, 0, 0, 0, 0);
        chk("R7 irq not yet on push edge", irq_stat, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R7 irq set at trigger count", irq_stat, 1);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R7 clear ignored while condition holds", irq_stat, 1);
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R1 pop after irq", pop_byte, 8'h01);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R7 clear once below trigger", irq_stat, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R1 drain order", pop_byte, 8'h03);

        // R6 R7: reprogram threshold to 0 (one byte)
        step(0, 0, 0, 1, 4'd0, 0, 0);
        chk("R6 threshold reprogram", thr_q, 0);
        step(1, 8'h44, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R7 irq at single byte with threshold 0", irq_stat, 1);
        step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);

        // R4 R8: fill, overflow, push and pop at full
        for (int i = 0; i < 16; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0, 0);
        chk("R3 full status", status_byte, 8'h20);
        chk("R2 occ at full", occ_m1, 15);
        chk("R4 no overflow yet", ovf_flag, 0);
        step(1, 8'hEE, 0, 0, 0, 0, 0);
        chk("R4 overflow flagged", ovf_flag, 1);
        chk("R4 occ unchanged on drop", occ_m1, 15);
        step(1, 8'h77, 1, 0, 0, 0, 0);
        chk("R8 pop at full returns oldest", pop_byte, 8'h10);
        chk("R8 still full after push and pop", status_byte, 8'h20);
        chk("R4 overflow sticky", ovf_flag, 1);
        step(0, 0, 0, 0, 0, 0, 1);
        chk("R4 overflow cleared", ovf_flag, 0);
        for (int i = 1; i < 16; i++) begin
            step(0, 0, 1, 0, 0, 0, 0);
            chk($sformatf("R1 R4 drain byte %0d", i), pop_byte, 8'h10 + 8'(i));
        end
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R8 byte accepted at full", pop_byte, 8'h77);
        chk("R3 empty after drain", status_byte, 8'h40);

        // R9: reset mid-operation
        step(1, 8'h99, 0, 0, 0, 0, 0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 status after second reset", status_byte, 8'h40);
        chk("R9 occ after second reset", occ_m1, 0);
        chk("R9 thr after second reset", thr_q, 15);
        chk("R9 irq after second reset", irq_stat, 0);
        chk("R9 pop byte after second reset", pop_byte, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule